// File: doc/BRIEF.md
# One-Plus-Lambda Evolution Engine

This block runs an evolution strategy over a feed-forward gate netlist. It holds one parent genome and produces a configurable number of mutated offspring per generation. Each offspring goes out on a valid/ready stream to an external evaluator. The evaluator returns one fitness score for each offspring. After the last score of a generation, the best offspring replaces the parent if it scores at least as well as the parent. Accepting an equal score lets the genome drift while its fitness stays the same. There is no recombination between genomes.

A genome is a list of `N_GATES` genes. Gate `g` may take its inputs only from the `N_IN` primary inputs (labels `0..N_IN-1`) or from gates before it (label `N_IN+j` for gate `j`).

Mutation works one gate per cycle. Two 16-bit LFSRs supply the random draws: one decides whether a gate mutates, and the other decides what changes.

The run starts on a `start` pulse. It ends when the parent's score reaches a target or the generation count reaches a limit.

Back-pressure rules:
- Offspring stream: once `off_valid` rises, it stays high and `off_genome` stays constant until a cycle with `off_ready` high.
- Score return: the engine raises `fit_ready` only between that handshake and the arrival of the score. A score is taken in a cycle with both `fit_valid` and `fit_ready` high.
- Only one offspring is outstanding at a time.

Top module: `evo_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `done`, `off_valid` and `fit_ready` are low, and `gen_count` and `best_fit` are zero.
- R2: When idle, a `start` pulse does four things: it loads `init_genome` as the parent, clears `best_fit`, `gen_count` and `done`, and begins the run. A `start` pulse while busy has no effect on the parent or the generation count.
- R3: The offspring stream keeps `off_valid` high and `off_genome` stable until `off_ready`. `fit_ready` is never high while `off_valid` is high, and it stays high from the handshake until a score is accepted.
- R4: Each gate of an offspring mutates when a 16-bit random sample, scaled to the range 0..99, is below `cfg_rate`. With `cfg_rate` = 0 the offspring equals the parent. With `cfg_rate` = 100 every gate takes a mutation draw.
- R5: Each gene is `{kind[2:0], src_b, src_a}`, where each source field is `$clog2(N_IN+N_GATES)` bits wide. Gate `g` sits at bits `[g*GENE_W +: GENE_W]`. A mutated gate changes either its kind or exactly one of its two sources, never more than one field.
- R6: A remapped source of gate `g` is below `N_IN+g`, which keeps the netlist feed-forward. A replaced kind lies in 0..6 (NAND, NOR, OR, AND, NOT, const-1, const-0).
- R7: Each generation emits `cfg_lambda` offspring, and a value of 0 acts as 1. `gen_count` rises by one after the last score of each generation.
- R8: At the end of a generation, the parent is replaced by the highest-scoring offspring when that score is greater than or equal to `best_fit`. Otherwise the parent and `best_fit` are kept. `best_fit` never decreases during a run.
- R9: When several offspring share the top score of a generation, the new parent is one of those tied offspring, picked pseudo-randomly.
- R10: `par_genome` does not change while offspring of a generation are being built, offered or scored.
- R11: After a generation's update, the run stops if `best_fit` >= `cfg_target` or `gen_count` >= `cfg_max_gen`. `done` then rises and `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run (accepted only when idle) |
| init_genome | input | GW | Initial parent genome |
| cfg_lambda | input | 8 | Offspring per generation |
| cfg_rate | input | 7 | Per-gate mutation probability in percent |
| cfg_target | input | FIT_W | Score that ends the run |
| cfg_max_gen | input | GEN_W | Generation limit |
| off_valid | output | 1 | Offspring genome valid |
| off_ready | input | 1 | Evaluator takes the offspring |
| off_genome | output | GW | Offspring genome |
| fit_valid | input | 1 | Score valid |
| fit_ready | output | 1 | Engine waits for a score |
| fit_score | input | FIT_W | Fitness of the last offspring |
| par_genome | output | GW | Current parent genome |
| best_fit | output | FIT_W | Parent's score |
| gen_count | output | GEN_W | Completed generations |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |

## Verification
The generation-end update and the stop decision fall in the same cycle, and both stop conditions can be true in it together. A run with a single offspring, a generation limit of one and a target below the returned score provokes that case. The bench then expects the new parent to be that offspring, `best_fit` to be the score, `gen_count` to be one and `done` to be high.

A second case puts a tied top score on the generation's last offspring. The bench then checks that the committed parent is one of the tied genomes that were captured.

// File: rtl/evo_pkg.sv
package evo_pkg;
  typedef enum logic [2:0] {
    K_NAND, K_NOR, K_OR, K_AND, K_NOT, K_ONE, K_ZERO
  } gate_kind_e;
  localparam int unsigned N_KINDS = 7;
  localparam int unsigned KIND_W = 3;

  typedef enum logic [2:0] {
    S_IDLE, S_BUILD, S_OFFER, S_WAIT, S_COMMIT
  } eng_state_e;
endpackage

// File: rtl/evo_lfsr16.sv
module evo_lfsr16 #(
  parameter logic [15:0] TAPS = 16'hB400,
  parameter logic [15:0] SEED = 16'h1
) (
  input  logic        clk,
  input  logic        rst,
  output logic [15:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= SEED;
    else     q <= q[0] ? ((q >> 1) ^ TAPS) : (q >> 1);
  end
endmodule

// File: rtl/evo_mutator.sv
module evo_mutator
  import evo_pkg::*;
#(
  parameter int N_IN    = 4,
  parameter int N_GATES = 8,
  localparam int SRC_W  = $clog2(N_IN + N_GATES),
  localparam int GENE_W = KIND_W + 2 * SRC_W,
  localparam int GIDX_W = (N_GATES > 1) ? $clog2(N_GATES) : 1
) (
  input  logic [GENE_W-1:0] gene_in,
  input  logic [GIDX_W-1:0] gate_idx,
  input  logic [15:0]       rnd_p,
  input  logic [15:0]       rnd_c,
  input  logic [6:0]        rate,
  output logic [GENE_W-1:0] gene_out,
  output logic              hit
);
  logic [22:0]      prod_p;
  logic [10:0]      prod_k;
  logic [SRC_W:0]   limit;
  logic [SRC_W+8:0] prod_s;
  logic [SRC_W-1:0] new_src;
  logic [KIND_W-1:0] new_kind;

  always_comb begin
    prod_p   = 23'(rnd_p) * 23'd100;
    hit      = prod_p[22:16] < rate;
    limit    = (SRC_W+1)'(N_IN) + (SRC_W+1)'(gate_idx);
    prod_s   = (SRC_W+9)'(rnd_c[15:8]) * (SRC_W+9)'(limit);
    new_src  = prod_s[SRC_W+7:8];
    prod_k   = 11'(rnd_c[15:8]) * 11'(N_KINDS);
    new_kind = prod_k[10:8];
    gene_out = gene_in;
    if (hit) begin
      if (!rnd_c[0])     gene_out[GENE_W-1 -: KIND_W] = new_kind;
      else if (rnd_c[1]) gene_out[2*SRC_W-1 -: SRC_W] = new_src;
      else               gene_out[SRC_W-1:0]          = new_src;
    end
  end
endmodule

// File: rtl/evo_select.sv
module evo_select #(
  parameter int GW    = 88,
  parameter int FIT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             first,
  input  logic             coin,
  input  logic [GW-1:0]    genome,
  input  logic [FIT_W-1:0] score,
  output logic [GW-1:0]    cand_genome,
  output logic [FIT_W-1:0] cand_fit
);
  logic load;
  assign load = take && (first || score > cand_fit || (score == cand_fit && coin));

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_genome <= '0;
      cand_fit    <= '0;
    end else if (load) begin
      cand_genome <= genome;
      cand_fit    <= score;
    end
  end
endmodule

// File: rtl/evo_engine.sv
module evo_engine
  import evo_pkg::*;
#(
  parameter int N_IN    = 4,
  parameter int N_GATES = 8,
  parameter int FIT_W   = 8,
  parameter int GEN_W   = 16,
  parameter logic [15:0] SEED_P = 16'hACE1,
  parameter logic [15:0] SEED_C = 16'h5EED,
  localparam int SRC_W  = $clog2(N_IN + N_GATES),
  localparam int GENE_W = KIND_W + 2 * SRC_W,
  localparam int GW     = N_GATES * GENE_W,
  localparam int GIDX_W = (N_GATES > 1) ? $clog2(N_GATES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [GW-1:0]    init_genome,
  input  logic [7:0]       cfg_lambda,
  input  logic [6:0]       cfg_rate,
  input  logic [FIT_W-1:0] cfg_target,
  input  logic [GEN_W-1:0] cfg_max_gen,
  output logic             off_valid,
  input  logic             off_ready,
  output logic [GW-1:0]    off_genome,
  input  logic             fit_valid,
  output logic             fit_ready,
  input  logic [FIT_W-1:0] fit_score,
  output logic [GW-1:0]    par_genome,
  output logic [FIT_W-1:0] best_fit,
  output logic [GEN_W-1:0] gen_count,
  output logic             busy,
  output logic             done
);
  eng_state_e        st;
  logic [GIDX_W-1:0] gidx;
  logic [7:0]        kidx;
  logic [GW-1:0]     par_q, off_q, cand_g;
  logic [FIT_W-1:0]  par_fit, cand_fit, new_best;
  logic [GEN_W-1:0]  gen_q, gen_nx;
  logic              done_q, take, last_off, hit;
  logic [15:0]       rnd_p, rnd_c;
  logic [GENE_W-1:0] mut_in, mut_out;

  evo_lfsr16 #(.TAPS(16'hB400), .SEED(SEED_P)) u_rp (.clk(clk), .rst(rst), .q(rnd_p));
  evo_lfsr16 #(.TAPS(16'hD008), .SEED(SEED_C)) u_rc (.clk(clk), .rst(rst), .q(rnd_c));

  assign mut_in = par_q[gidx*GENE_W +: GENE_W];

  evo_mutator #(.N_IN(N_IN), .N_GATES(N_GATES)) u_mut (
    .gene_in(mut_in), .gate_idx(gidx), .rnd_p(rnd_p), .rnd_c(rnd_c),
    .rate(cfg_rate), .gene_out(mut_out), .hit(hit)
  );

  assign take     = (st == S_WAIT) && fit_valid;
  assign last_off = ({1'b0, kidx} + 9'd1) >= {1'b0, cfg_lambda};

  evo_select #(.GW(GW), .FIT_W(FIT_W)) u_sel (
    .clk(clk), .rst(rst), .take(take), .first(kidx == 8'd0), .coin(rnd_c[5]),
    .genome(off_q), .score(fit_score), .cand_genome(cand_g), .cand_fit(cand_fit)
  );

  assign new_best = (cand_fit >= par_fit) ? cand_fit : par_fit;
  assign gen_nx   = gen_q + GEN_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; gidx <= '0; kidx <= '0; par_q <= '0; off_q <= '0;
      par_fit <= '0; gen_q <= '0; done_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          par_q <= init_genome; par_fit <= '0; gen_q <= '0; done_q <= 1'b0;
          gidx <= '0; kidx <= '0; st <= S_BUILD;
        end
        S_BUILD: begin
          off_q[gidx*GENE_W +: GENE_W] <= mut_out;
          if (gidx == GIDX_W'(N_GATES - 1)) begin
            gidx <= '0; st <= S_OFFER;
          end else gidx <= gidx + GIDX_W'(1);
        end
        S_OFFER: if (off_ready) st <= S_WAIT;
        S_WAIT: if (fit_valid) begin
          if (last_off) st <= S_COMMIT;
          else begin kidx <= kidx + 8'd1; st <= S_BUILD; end
        end
        S_COMMIT: begin
          if (cand_fit >= par_fit) begin par_q <= cand_g; par_fit <= cand_fit; end
          gen_q <= gen_nx; kidx <= '0;
          if (new_best >= cfg_target || gen_nx >= cfg_max_gen) begin
            done_q <= 1'b1; st <= S_IDLE;
          end else st <= S_BUILD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign off_valid  = (st == S_OFFER);
  assign fit_ready  = (st == S_WAIT);
  assign off_genome = off_q;
  assign par_genome = par_q;
  assign best_fit   = par_fit;
  assign gen_count  = gen_q;
  assign busy       = (st != S_IDLE);
  assign done       = done_q;

  // R3: offered genome held under back-pressure
  p_offer_hold_r3: assert property (@(posedge clk) disable iff (rst)
    off_valid && !off_ready |=> off_valid && $stable(off_genome));
  // R3: score window never overlaps an offer
  p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst)
    !(off_valid && fit_ready));
  // R4: zero rate leaves the gene untouched
  p_rate_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (st == S_BUILD && cfg_rate == 7'd0) |-> mut_out == mut_in);
  // R5: at most one field of a gene changes
  p_one_field_r5: assert property (@(posedge clk) disable iff (rst)
    (st == S_BUILD) |-> $countones({mut_out[GENE_W-1 -: KIND_W] != mut_in[GENE_W-1 -: KIND_W],
                                    mut_out[2*SRC_W-1 -: SRC_W] != mut_in[2*SRC_W-1 -: SRC_W],
                                    mut_out[SRC_W-1:0] != mut_in[SRC_W-1:0]}) <= 1);
  // R6: a remapped source points backwards only
  p_src_ff_r6: assert property (@(posedge clk) disable iff (rst)
    (st == S_BUILD && mut_out[SRC_W-1:0] != mut_in[SRC_W-1:0]) |->
      (32'(mut_out[SRC_W-1:0]) < N_IN + 32'(gidx)));
  // R8: best score never drops within a run
  p_best_mono_r8: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE) |=> best_fit >= $past(best_fit));
  // R10: parent frozen while a generation is in flight
  p_par_still_r10: assert property (@(posedge clk) disable iff (rst)
    (st == S_BUILD || st == S_OFFER || st == S_WAIT) |=> $stable(par_genome));
endmodule

// File: tb/evo_engine_test.sv
module evo_engine_test;
  localparam int N_IN = 4, N_GATES = 8, FIT_W = 8, GEN_W = 16;
  localparam int SRC_W = $clog2(N_IN + N_GATES);
  localparam int GENE_W = 3 + 2 * SRC_W;
  localparam int GW = N_GATES * GENE_W;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [GW-1:0] init_genome = '0;
  logic [7:0] cfg_lambda = 8'd1;
  logic [6:0] cfg_rate = '0;
  logic [FIT_W-1:0] cfg_target = '1;
  logic [GEN_W-1:0] cfg_max_gen = 16'd1;
  logic off_ready = 1'b0, fit_valid = 1'b0;
  logic [FIT_W-1:0] fit_score = '0;
  logic off_valid, fit_ready, busy, done;
  logic [GW-1:0] off_genome, par_genome;
  logic [FIT_W-1:0] best_fit;
  logic [GEN_W-1:0] gen_count;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  evo_engine uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit legal(input logic [GW-1:0] o, input logic [GW-1:0] p);
    legal = 1'b1;
    for (int i = 0; i < N_GATES; i++) begin
      logic [GENE_W-1:0] a, b;
      int nd;
      a = o[i*GENE_W +: GENE_W];
      b = p[i*GENE_W +: GENE_W];
      nd = int'(a[GENE_W-1 -: 3] != b[GENE_W-1 -: 3]) +
           int'(a[2*SRC_W-1 -: SRC_W] != b[2*SRC_W-1 -: SRC_W]) +
           int'(a[SRC_W-1:0] != b[SRC_W-1:0]);
      if (nd > 1) legal = 1'b0;
      if (a[GENE_W-1 -: 3] > 3'd6) legal = 1'b0;
      if (int'(a[2*SRC_W-1 -: SRC_W]) >= N_IN + i) legal = 1'b0;
      if (int'(a[SRC_W-1:0]) >= N_IN + i) legal = 1'b0;
    end
  endfunction

  function automatic logic [GW-1:0] make_init(input int salt);
    make_init = '0;
    for (int i = 0; i < N_GATES; i++)
      make_init[i*GENE_W +: GENE_W] = {3'((i + salt) % 7), SRC_W'(0), SRC_W'((i + salt) % (N_IN + i))};
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // serve one offspring; hold = cycles of back-pressure
  task automatic serve(input int score, input int hold, output logic [GW-1:0] g);
    logic [GW-1:0] p;
    p = par_genome;
    while (!off_valid) @(negedge clk);
    g = off_genome;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(off_valid && off_genome == g && !fit_ready, "R3 hold", 128'(off_valid), 128'(1));
    end
    off_ready = 1'b1; @(negedge clk); off_ready = 1'b0;
    chk(fit_ready && !off_valid, "R3 score window", 128'(fit_ready), 128'(1));
    while (!fit_ready) @(negedge clk);
    fit_score = FIT_W'(score); fit_valid = 1'b1;
    @(negedge clk); fit_valid = 1'b0;
    chk(par_genome == p, "R10 parent frozen", 128'(par_genome), 128'(p));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !done && !off_valid && !fit_ready, "R1 idle flags", {busy, done, off_valid, fit_ready}, 0);
    chk(gen_count == 0 && best_fit == 0, "R1 counters", {gen_count, best_fit}, 0);
  endtask

  task automatic t_copy();
    logic [GW-1:0] g;
    init_genome = make_init(1); cfg_rate = 7'd0; cfg_lambda = 8'd3;
    cfg_max_gen = 16'd2; cfg_target = 8'd255;
    pulse_start();
    chk(par_genome == init_genome && busy && gen_count == 0 && best_fit == 0, "R2 start load",
        128'(par_genome), 128'(init_genome));
    for (int k = 0; k < 3; k++) begin
      serve(5, 0, g);
      chk(g == init_genome, "R4 rate zero copy", 128'(g), 128'(init_genome));
    end
    @(negedge clk);
    chk(gen_count == 1 && best_fit == 5 && busy, "R7 gen step", {gen_count, best_fit}, {16'd1, 8'd5});
    for (int k = 0; k < 3; k++) serve(3, 0, g);
    @(negedge clk);
    chk(best_fit == 5, "R8 lower kept", 128'(best_fit), 128'(5));
    chk(done && !busy && gen_count == 2, "R11 gen limit", {done, busy, gen_count}, {1'b1, 1'b0, 16'd2});
  endtask

  task automatic t_mutate();
    logic [GW-1:0] g, pick, p0;
    logic [GW-1:0] ties[4];
    bit any_diff, member;
    int sc0[4] = '{10, 20, 40, 30};
    init_genome = make_init(3); cfg_rate = 7'd100; cfg_lambda = 8'd4;
    cfg_max_gen = 16'd3; cfg_target = 8'd255;
    pulse_start();
    any_diff = 1'b0;
    for (int k = 0; k < 4; k++) begin
      serve(sc0[k], (k == 0) ? 3 : 0, g);
      chk(legal(g, init_genome), "R5 R6 gene rules", 128'(g), 128'(init_genome));
      if (g != init_genome) any_diff = 1'b1;
      if (k == 2) pick = g;
    end
    @(negedge clk);
    chk(par_genome == pick && best_fit == 40, "R8 best offspring", 128'(par_genome), 128'(pick));
    p0 = par_genome;
    for (int k = 0; k < 4; k++) begin
      serve(k + 1, 0, g);
      chk(legal(g, p0), "R5 R6 gene rules", 128'(g), 128'(p0));
      if (g != p0) any_diff = 1'b1;
    end
    @(negedge clk);
    chk(par_genome == p0 && best_fit == 40, "R8 parent kept", 128'(par_genome), 128'(p0));
    chk(any_diff, "R4 full rate mutates", 128'(any_diff), 128'(1));
    for (int k = 0; k < 4; k++) serve(40, 0, ties[k]);
    @(negedge clk);
    member = 1'b0;
    foreach (ties[k]) if (par_genome == ties[k]) member = 1'b1;
    chk(member && best_fit == 40, "R9 tie pick", 128'(member), 128'(1));
    chk(done && gen_count == 3, "R11 gen limit", 128'(gen_count), 128'(3));
  endtask

  task automatic t_both_stop();
    logic [GW-1:0] g;
    init_genome = make_init(2); cfg_rate = 7'd50; cfg_lambda = 8'd0;
    cfg_max_gen = 16'd1; cfg_target = 8'd7;
    pulse_start();
    serve(9, 0, g);
    @(negedge clk);
    chk(par_genome == g && best_fit == 9, "R8 single offspring", 128'(par_genome), 128'(g));
    chk(done && !busy && gen_count == 1, "R7 R11 lambda zero stop", {done, busy, gen_count}, {1'b1, 1'b0, 16'd1});
  endtask

  task automatic t_target();
    logic [GW-1:0] g, p;
    init_genome = make_init(4); cfg_rate = 7'd30; cfg_lambda = 8'd2;
    cfg_max_gen = 16'd100; cfg_target = 8'd50;
    pulse_start();
    serve(20, 0, g); serve(10, 0, g);
    @(negedge clk);
    p = par_genome;
    init_genome = make_init(5);
    pulse_start();
    chk(par_genome == p && gen_count == 1 && busy, "R2 start ignored", 128'(gen_count), 128'(1));
    serve(60, 0, g); serve(5, 0, g);
    @(negedge clk);
    chk(done && gen_count == 2 && best_fit == 60, "R11 target stop", {gen_count, best_fit}, {16'd2, 8'd60});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_copy();
    t_mutate();
    t_both_stop();
    t_target();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule